// File: doc/BRIEF.md
# Repeated Syndrome Agreement Logger

This block gathers ancilla measurement results for a nine-data-qubit code protected by twelve two-qubit parity checks. The data qubits form a 3x3 grid. Six X-type checks each compare two vertically neighbouring qubits, and six Z-type checks each compare two horizontally neighbouring qubits. Each result arrives as one bit on a valid strobe, tagged with the ancilla number and a round number. A check result is trusted only when the same ancilla reports twice in a row, in the same round, with the same value. A disagreeing pair is dropped and counted.

Trusted results are never used to steer the qubits while the memory runs. Each one that reports a flipped parity toggles one bit of a classical X or Z frame. When the final logical measurement arrives, the block corrects the raw bit with the parity of the chosen frame. It shows both frames, raises a one-cycle done pulse and starts a fresh epoch.

Top module: `syn_agree_logger`

## Requirements
- R1: Reset behaviour. While `rst_n` is low at a clock edge, the block clears `done`, `logical_out`, `corr_x`, `corr_z`, `mismatch_cnt` and every stored first result.
- R2: A first result leaves the visible frames unchanged. A first result is an accepted measurement for an ancilla that holds no stored result.
- R3: A second result completes a pair. The second result must name the same ancilla with the same `meas_round` as the stored one. If the two values agree and are 1, one frame bit is toggled. If they agree and are 0, no frame bit changes. Either way the stored result is released, so two committed 1-pairs on one ancilla cancel.
- R4: Ancilla `a` in 0..5 is an X-type check with `p = a/3` and `c = a%3`. A committed 1 on it toggles X-frame bit `(p+1)*3 + c`. Qubit index is row*3 + column.
- R5: Ancilla `a` in 6..11 is a Z-type check with `m = a-6`, `p = m/3` and `r = m%3`. A committed 1 on it toggles Z-frame bit `r*3 + p + 1`.
- R6: A completed pair whose two values differ changes no frame bit. It adds one to `mismatch_cnt` in the cycle after the second result.
- R7: `mismatch_cnt` saturates at its all-ones value (15 by default) and holds there.
- R8: A second result for an ancilla that carries a different round replaces the stored result. It commits nothing and counts no mismatch.
- R9: A measurement whose ancilla number is 12 or more is ignored.
- R10: When `rd_valid` is sampled high, `done` is high in the next cycle, for that cycle only. In that cycle `corr_x` and `corr_z` show the frames as they stood before the readout. `logical_out` equals `rd_bit` XOR the parity of the X frame when `rd_basis`=0, or of the Z frame when `rd_basis`=1. These outputs then hold until the next readout.
- R11: A readout clears both frames and every stored first result. `mismatch_cnt` is kept.
- R12: A measurement presented in the same cycle as `rd_valid` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| meas_valid | input | 1 | An ancilla result is present |
| meas_anc | input | 4 | Ancilla number of the result |
| meas_round | input | 4 | Round tag of the result |
| meas_bit | input | 1 | Measured parity value |
| rd_valid | input | 1 | Final logical readout is present |
| rd_basis | input | 1 | 0 selects the X frame, 1 the Z frame |
| rd_bit | input | 1 | Raw logical measurement |
| done | output | 1 | One-cycle pulse after a readout |
| logical_out | output | 1 | Corrected logical bit |
| corr_x | output | 9 | X frame captured at readout |
| corr_z | output | 9 | Z frame captured at readout |
| mismatch_cnt | output | 4 | Saturating count of disagreeing pairs |

## Verification
Every result comes out one register after its stimulus. The mismatch count moves on the clock edge that samples the second result of a pair. The done pulse, the corrected bit and both frames appear on the edge that samples `rd_valid`. Frame effects can only be seen through a readout, so each frame check is one readout placed after the pairs it covers. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge. It also checks `done` one cycle later to confirm the pulse has ended.

// File: rtl/slg_pkg.sv
// Shared types and check-to-qubit mapping for the syndrome agreement logger.
// Assumes a square DIM x DIM data grid, with qubit index = row*DIM + column.
package slg_pkg;

    typedef enum logic {
        FRAME_SEL_X = 1'b0,
        FRAME_SEL_Z = 1'b1
    } frame_sel_e;

    // Qubit toggled by X-type check k (vertical neighbours, lower one taken).
    function automatic int xchk_target(input int k, input int dim);
        int p;
        int c;
        p = k / dim;
        c = k % dim;
        return (p + 1) * dim + c;
    endfunction

    // Qubit toggled by Z-type check k (horizontal neighbours, right one taken).
    function automatic int zchk_target(input int k, input int dim);
        int m;
        int p;
        int r;
        m = k - dim * (dim - 1);
        p = m / dim;
        r = m % dim;
        return r * dim + p + 1;
    endfunction

endpackage

// File: rtl/slg_pair_tracker.sv
// Holds the first result of each ancilla and pairs it with the next result.
// Assumes at most one measurement per cycle. flush drops every stored result
// and blocks the measurement of that cycle. Event outputs are combinational.
module slg_pair_tracker #(
    parameter int NUM_ANC = 12,
    parameter int ANC_W   = 4,
    parameter int ROUND_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_vld,
    input  logic [ANC_W-1:0]   in_anc,
    input  logic [ROUND_W-1:0] in_rnd,
    input  logic               in_bit,
    output logic               ev_agree,
    output logic               ev_mis,
    output logic [ANC_W-1:0]   ev_anc,
    output logic               ev_bit
);

    logic               pend_vld [NUM_ANC];
    logic               pend_bit [NUM_ANC];
    logic [ROUND_W-1:0] pend_rnd [NUM_ANC];

    logic take;
    logic hit_pend;
    logic hit_bit;

    // Accept a measurement only when no readout flush is in progress.
    assign take = in_vld && !flush;

    // Look up the stored result of the addressed ancilla, if one exists.
    always_comb begin
        hit_pend = 1'b0;
        hit_bit  = 1'b0;
        for (int a = 0; a < NUM_ANC; a++) begin
            if (in_anc == ANC_W'(a)) begin
                hit_pend = pend_vld[a] && (pend_rnd[a] == in_rnd);
                hit_bit  = pend_bit[a];
            end
        end
    end

    // Classify the completed pair, if there is one.
    always_comb begin
        ev_agree = take && hit_pend && (hit_bit == in_bit);
        ev_mis   = take && hit_pend && (hit_bit != in_bit);
        ev_anc   = in_anc;
        ev_bit   = in_bit;
    end

    for (genvar a = 0; a < NUM_ANC; a++) begin : g_slot
        logic sel;
        logic pairs;
        assign sel   = take && (in_anc == ANC_W'(a));
        assign pairs = pend_vld[a] && (pend_rnd[a] == in_rnd);

        // Store a first result, or release it when its partner arrives.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                pend_vld[a] <= 1'b0;
                pend_bit[a] <= 1'b0;
                pend_rnd[a] <= '0;
            end else if (sel) begin
                if (pairs) begin
                    pend_vld[a] <= 1'b0;
                end else begin
                    pend_vld[a] <= 1'b1;
                    pend_bit[a] <= in_bit;
                    pend_rnd[a] <= in_rnd;
                end
            end
        end
    end

endmodule

// File: rtl/slg_frame_accum.sv
// Running X and Z correction frames, toggled by committed syndromes of value 1.
// Assumes ancillas 0..NUM_ANC/2-1 are X-type and the rest are Z-type.
// flush clears both frames.
module slg_frame_accum
    import slg_pkg::*;
#(
    parameter int DIM     = 3,
    parameter int NUM_ANC = 2 * DIM * (DIM - 1),
    parameter int ANC_W   = 4,
    parameter int NQ      = DIM * DIM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             commit,
    input  logic [ANC_W-1:0] anc,
    input  logic             syn_bit,
    output logic [NQ-1:0]    xfrm,
    output logic [NQ-1:0]    zfrm
);

    localparam int HALF = NUM_ANC / 2;

    logic [NUM_ANC-1:0] hit;
    logic [NQ-1:0]      xtgl;
    logic [NQ-1:0]      ztgl;

    for (genvar k = 0; k < NUM_ANC; k++) begin : g_hit
        assign hit[k] = commit && syn_bit && (anc == ANC_W'(k));
    end

    // Turn the committed check into a one-hot toggle on its mapped qubit.
    always_comb begin
        xtgl = '0;
        ztgl = '0;
        for (int k = 0; k < NUM_ANC; k++) begin
            if (hit[k]) begin
                if (k < HALF) xtgl[xchk_target(k, DIM)] = 1'b1;
                else          ztgl[zchk_target(k, DIM)] = 1'b1;
            end
        end
    end

    // Fold the toggles into the frames; a flush starts an empty epoch.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            xfrm <= '0;
            zfrm <= '0;
        end else begin
            xfrm <= xfrm ^ xtgl;
            zfrm <= zfrm ^ ztgl;
        end
    end

endmodule

// File: rtl/slg_sat_counter.sv
// Saturating up-counter for disagreeing measurement pairs.
// Assumes at most one increment per cycle. Only reset clears it.
module slg_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up on each event and stop at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/syn_agree_logger.sv
// Top of the repeated syndrome agreement logger. It pairs repeated ancilla
// results, logs agreeing flips into X/Z frames and counts disagreements.
// On the final readout it emits the corrected logical bit and both frames.
// Assumes one measurement per cycle; a readout has priority and clears the
// epoch.
module syn_agree_logger
    import slg_pkg::*;
#(
    parameter int DIM     = 3,
    parameter int ROUND_W = 4,
    parameter int CNT_W   = 4,
    parameter int NUM_ANC = 2 * DIM * (DIM - 1),
    parameter int ANC_W   = $clog2(NUM_ANC),
    parameter int NQ      = DIM * DIM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               meas_valid,
    input  logic [ANC_W-1:0]   meas_anc,
    input  logic [ROUND_W-1:0] meas_round,
    input  logic               meas_bit,
    input  logic               rd_valid,
    input  logic               rd_basis,
    input  logic               rd_bit,
    output logic               done,
    output logic               logical_out,
    output logic [NQ-1:0]      corr_x,
    output logic [NQ-1:0]      corr_z,
    output logic [CNT_W-1:0]   mismatch_cnt
);

    logic             ev_agree;
    logic             ev_mis;
    logic [ANC_W-1:0] ev_anc;
    logic             ev_bit;
    logic [NQ-1:0]    xfrm;
    logic [NQ-1:0]    zfrm;
    frame_sel_e       sel;

    slg_pair_tracker #(
        .NUM_ANC (NUM_ANC),
        .ANC_W   (ANC_W),
        .ROUND_W (ROUND_W)
    ) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rd_valid),
        .in_vld   (meas_valid),
        .in_anc   (meas_anc),
        .in_rnd   (meas_round),
        .in_bit   (meas_bit),
        .ev_agree (ev_agree),
        .ev_mis   (ev_mis),
        .ev_anc   (ev_anc),
        .ev_bit   (ev_bit)
    );

    slg_frame_accum #(
        .DIM     (DIM),
        .NUM_ANC (NUM_ANC),
        .ANC_W   (ANC_W),
        .NQ      (NQ)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rd_valid),
        .commit  (ev_agree),
        .anc     (ev_anc),
        .syn_bit (ev_bit),
        .xfrm    (xfrm),
        .zfrm    (zfrm)
    );

    slg_sat_counter #(
        .CNT_W (CNT_W)
    ) u_mis (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_mis),
        .cnt   (mismatch_cnt)
    );

    assign sel = frame_sel_e'(rd_basis);

    // Capture the net correction and the corrected logical bit at readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            logical_out <= 1'b0;
            corr_x      <= '0;
            corr_z      <= '0;
        end else begin
            done <= rd_valid;
            if (rd_valid) begin
                corr_x      <= xfrm;
                corr_z      <= zfrm;
                logical_out <= rd_bit ^ ((sel == FRAME_SEL_Z) ? ^zfrm : ^xfrm);
            end
        end
    end

endmodule

// File: rtl/syn_agree_logger_chk.sv
// Port-level properties of the syndrome agreement logger, attached by bind.
module syn_agree_logger_chk #(
    parameter int ANC_W   = 4,
    parameter int CNT_W   = 4,
    parameter int NQ      = 9,
    parameter int NUM_ANC = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_valid,
    input logic [ANC_W-1:0] meas_anc,
    input logic             rd_valid,
    input logic             done,
    input logic             logical_out,
    input logic [NQ-1:0]    corr_x,
    input logic [NQ-1:0]    corr_z,
    input logic [CNT_W-1:0] mismatch_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R10: a readout produces done in the next cycle.
    a_r10_done_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> done);

    // R10: done appears only after a readout.
    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !done);

    // R10: the outputs hold between readouts.
    a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> ($stable(corr_x) && $stable(corr_z) && $stable(logical_out)));

    // R6: the count moves only when a measurement is presented.
    a_r6_count_needs_meas: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(mismatch_cnt));

    // R6: the count rises by at most one per cycle.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mismatch_cnt == $past(mismatch_cnt)) ||
                  ({1'b0, mismatch_cnt} == {1'b0, $past(mismatch_cnt)} + 1'b1)));

    // R7: a saturated count stays saturated.
    a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_cnt == CNT_MAX) |=> (mismatch_cnt == CNT_MAX));

    // R9: an out-of-range ancilla never moves the count.
    a_r9_bad_anc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && (meas_anc >= ANC_W'(NUM_ANC))) |=> $stable(mismatch_cnt));

    // R12: a measurement that collides with a readout never moves the count.
    a_r12_collision_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && rd_valid) |=> $stable(mismatch_cnt));

endmodule

bind syn_agree_logger syn_agree_logger_chk #(
    .ANC_W   (ANC_W),
    .CNT_W   (CNT_W),
    .NQ      (NQ),
    .NUM_ANC (NUM_ANC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_valid   (meas_valid),
    .meas_anc     (meas_anc),
    .rd_valid     (rd_valid),
    .done         (done),
    .logical_out  (logical_out),
    .corr_x       (corr_x),
    .corr_z       (corr_z),
    .mismatch_cnt (mismatch_cnt)
);

// File: tb/syn_agree_logger_tb.sv
`timescale 1ns/1ps
module syn_agree_logger_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_valid = 1'b0;
    logic [3:0] meas_anc = '0;
    logic [3:0] meas_round = '0;
    logic       meas_bit = 1'b0;
    logic       rd_valid = 1'b0;
    logic       rd_basis = 1'b0;
    logic       rd_bit = 1'b0;
    logic       done;
    logic       logical_out;
    logic [8:0] corr_x;
    logic [8:0] corr_z;
    logic [3:0] mismatch_cnt;

    int checks = 0;
    int failures = 0;
    logic [8:0] mx = '0;
    logic [8:0] mz = '0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    syn_agree_logger u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_valid   (meas_valid),
        .meas_anc     (meas_anc),
        .meas_round   (meas_round),
        .meas_bit     (meas_bit),
        .rd_valid     (rd_valid),
        .rd_basis     (rd_basis),
        .rd_bit       (rd_bit),
        .done         (done),
        .logical_out  (logical_out),
        .corr_x       (corr_x),
        .corr_z       (corr_z),
        .mismatch_cnt (mismatch_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model frame toggle, computed from the mapping in R4/R5.
    task automatic model_toggle(input int a);
        if (a < 6) mx[((a / 3) + 1) * 3 + (a % 3)] = ~mx[((a / 3) + 1) * 3 + (a % 3)];
        else       mz[((a - 6) % 3) * 3 + ((a - 6) / 3) + 1] = ~mz[((a - 6) % 3) * 3 + ((a - 6) / 3) + 1];
    endtask

    task automatic meas(input int a, input int r, input logic b);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_anc   = 4'(a);
        meas_round = 4'(r);
        meas_bit   = b;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic readout(input string req, input logic basis, input logic b);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_basis = basis;
        rd_bit   = b;
        @(posedge clk);
        #1;
        chk({req, " done"}, 32'(done), 32'd1);
        chk({req, " corr_x"}, 32'(corr_x), 32'(mx));
        chk({req, " corr_z"}, 32'(corr_z), 32'(mz));
        chk({req, " logical"}, 32'(logical_out), 32'(b ^ (basis ? ^mz : ^mx)));
        @(negedge clk);
        rd_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 done pulse ends", 32'(done), 32'd0);
        mx = '0;
        mz = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state under reset.
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 corr_x", 32'(corr_x), 32'd0);
        chk("R1 corr_z", 32'(corr_z), 32'd0);
        chk("R1 count", 32'(mismatch_cnt), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 and R5: each ancilla alone, both frame selections.
        for (int a = 0; a < 12; a++) begin
            meas(a, a, 1'b1);
            meas(a, a, 1'b1);
            model_toggle(a);
            readout((a < 6) ? "R4 single" : "R5 single", a[0], a[1]);
        end

        // R3: all ancillas at once with 1s, then a 0-pair, then cancellation.
        for (int a = 0; a < 12; a++) begin
            meas(a, 5, 1'b1);
            meas(a, 5, 1'b1);
            model_toggle(a);
        end
        meas(4, 6, 1'b0);
        meas(4, 6, 1'b0);
        meas(7, 6, 1'b1);
        meas(7, 6, 1'b1);
        model_toggle(7);
        readout("R3 accumulate", 1'b0, 1'b1);
        meas(2, 1, 1'b1);
        meas(2, 1, 1'b1);
        meas(2, 2, 1'b1);
        meas(2, 2, 1'b1);
        readout("R3 cancel", 1'b0, 1'b0);

        // R2 and R11: a lone first result, then its partner after a readout.
        meas(9, 3, 1'b1);
        readout("R2 lone first", 1'b1, 1'b0);
        meas(9, 3, 1'b1);
        readout("R11 pending cleared", 1'b1, 1'b1);

        // R8: a round change replaces the stored result.
        meas(3, 1, 1'b0);
        meas(3, 2, 1'b1);
        chk("R8 no count", 32'(mismatch_cnt), 32'(exp_cnt));
        meas(3, 2, 1'b1);
        model_toggle(3);
        readout("R8 replaced", 1'b0, 1'b0);

        // R9: out-of-range ancillas.
        for (int a = 12; a < 16; a++) begin
            meas(a, 0, 1'b0);
            meas(a, 0, 1'b1);
        end
        chk("R9 no count", 32'(mismatch_cnt), 32'(exp_cnt));
        readout("R9 no frame", 1'b0, 1'b1);

        // R12: a collision with a readout drops the measurement.
        meas(0, 4, 1'b1);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_basis = 1'b0;
        rd_bit = 1'b0;
        meas_valid = 1'b1;
        meas_anc = 4'd0;
        meas_round = 4'd4;
        meas_bit = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        meas_valid = 1'b0;
        meas(0, 4, 1'b1);
        readout("R12 dropped", 1'b0, 1'b0);

        // R6 and R7: disagreeing pairs, counted up to saturation.
        for (int n = 0; n < 18; n++) begin
            meas(n % 12, 7, 1'b0);
            meas(n % 12, 7, 1'b1);
            if (exp_cnt < 15) exp_cnt++;
            chk((n < 15) ? "R6 count" : "R7 saturate", 32'(mismatch_cnt), 32'(exp_cnt));
        end
        readout("R6 no frame", 1'b1, 1'b0);
        chk("R11 count kept", 32'(mismatch_cnt), 32'd15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule